// File: doc/BRIEF.md
# Pager RF Battery-Saving Sequencer

This block drives the three duty-cycling lines of a paging receiver's radio front end. These are a main RF enable, a PLL setup enable and a DC-level adjustment pulse. Frame timing logic elsewhere decides which codeword windows must be sampled. For each one it issues a single-cycle strobe on a bit boundary, a fixed horizon of `HORIZON` bit periods before the window opens. The sequencer counts bit periods from that strobe. It raises each enable ahead of the window by its own programmed lead and holds it through the `WIN_BITS`-bit window.

Bit periods come from the system clock through a divider chosen by the rate select. The two lead codes are 6-bit values in bit periods, and each has its own largest legal code. A code above that limit is clamped. The same happens to an ordering violation, where the PLL lead is not longer than the RF lead: the sequencer raises a sticky configuration flag. The DC-adjust line has two behaviours, chosen by an option pin, and it depends on the decoder mode. A break request shuts everything down at the next bit boundary.

A strobe that arrives while a window is open starts the next countdown without cutting the open window short. At the close of the window the lines then stay high if the new lead has already begun. A strobe that arrives during a countdown restarts that countdown. Every pin is a level or a single-cycle strobe, and no data path carries flow control.

Top module: `pager_bs_seq`

## Requirements
- R1: While reset is asserted and after it is released, with no strobe yet seen, `rf_en`, `pll_en`, `dc_adj` and `cfg_err` are all 0.
- R2: One bit period is 150, 64 or 32 clocks for `rate_sel` 00, 01 or 1x. The window opens `HORIZON` (64) bit periods after the clock edge that samples `win_start`, and it lasts `WIN_BITS` (32) bit periods. `rf_en` is still high in the last clock of the window.
- R3: `rf_en` rises `N` bit periods before the window opens, where `N` is the clamped `rf_lead` (N=0: it rises with the window). It stays high for the whole window.
- R4: `pll_en` rises `M` bit periods before the window opens, where `M` is the clamped `pll_lead`. It stays high for the whole window. When M > N, `pll_en` is high whenever `rf_en` is.
- R5: `rf_lead` codes 62 and 63 act as 61. `pll_lead` code 63 acts as 62.
- R6: `cfg_err` is set at a strobe when `rf_lead` > 61, `pll_lead` > 62, or clamped M <= clamped N. Once set, it stays high until reset.
- R7: With `dc_opt`=0, `dc_adj` is high only in idle mode (`dec_mode`=00). It rises with `rf_en` and falls when the window opens.
- R8: With `dc_opt`=1, `dc_adj` is high for the whole window in idle mode. In lock mode (`dec_mode`=10) it is high only if `win_sync` was 1 with the strobe. Otherwise it stays low.
- R9: In preamble mode (`dec_mode`=01, and likewise 11), `dc_adj` stays low for either option.
- R10: All three outputs are low from the clock edge that ends the window, unless a newer countdown has already reached its lead. In that case the affected lines stay high with no gap.
- R11: After `brk` is sampled, the countdown and the window are cancelled at the next bit boundary, so that all outputs are low within one bit period. A cancelled window does not reopen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (nominally 76.8 kHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 2 | Bit-rate select: 00 slow, 01 mid, 1x fast |
| rf_lead | input | 6 | RF enable lead in bit periods (legal 0..61) |
| pll_lead | input | 6 | PLL enable lead in bit periods (legal 0..62) |
| dc_opt | input | 1 | DC-adjust behaviour select |
| dec_mode | input | 2 | Decoder mode: 00 idle, 01 preamble, 10 lock |
| win_start | input | 1 | One-cycle strobe, HORIZON bit periods before a window |
| win_sync | input | 1 | With the strobe: the window carries the sync codeword |
| brk | input | 1 | One-cycle break request |
| rf_en | output | 1 | Main RF enable |
| dc_adj | output | 1 | DC-level adjustment pulse |
| pll_en | output | 1 | PLL setup enable |
| cfg_err | output | 1 | Sticky lead configuration error |

## Verification
The bench compares all three lines clock by clock against a model written from the requirements. It does this over whole strobe-to-window runs at every rate, both DC options and all three modes, including the leads 0, 61 and 62 and the clamped codes 63. An off-by-one in the prescaler, countdown or window counter would show up as a line rising or falling one clock or one bit period away from the model. A wrong clamp would put the rise two bit periods early. It also places a second strobe inside an open window so that the new lead covers the window's end. A design that always drops its lines at window close would show a gap there. A break in the middle of a window must darken every line within a bit period and must not reopen the window, which catches a break that is ignored or only delays the close.

// File: rtl/bs_pkg.sv
`timescale 1ns/1ps
package bs_pkg;
  localparam int LEAD_W = 6;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_PRE  = 2'b01,
    MODE_LOCK = 2'b10,
    MODE_RSVD = 2'b11
  } bs_mode_e;
endpackage

// File: rtl/bs_bit_tick.sv
`timescale 1ns/1ps
// Bit-period prescaler: tick is high for one clock at the end of each bit.
module bs_bit_tick #(
  parameter int DIV_SLOW = 150,
  parameter int DIV_MID  = 64,
  parameter int DIV_FAST = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate_sel,
  input  logic       resync,
  output logic       tick
);
  localparam int MAX_AB = (DIV_SLOW > DIV_MID) ? DIV_SLOW : DIV_MID;
  localparam int MAXD   = (MAX_AB > DIV_FAST) ? MAX_AB : DIV_FAST;
  localparam int CNT_W  = $clog2(MAXD);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] div_m1;

  always_comb begin
    unique case (rate_sel)
      2'b00:   div_m1 = CNT_W'(DIV_SLOW - 1);
      2'b01:   div_m1 = CNT_W'(DIV_MID - 1);
      default: div_m1 = CNT_W'(DIV_FAST - 1);
    endcase
  end

  assign tick = (cnt >= div_m1);

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (resync || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  // With a steady rate the count never passes the last step of a bit.
  assert_tick_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(rate_sel) |-> (cnt <= div_m1));
endmodule

// File: rtl/bs_lead_clamp.sv
`timescale 1ns/1ps
// Limits a lead code to its largest legal value and reports an illegal code.
module bs_lead_clamp
  import bs_pkg::*;
#(
  parameter int MAX_CODE = 61
) (
  input  logic [LEAD_W-1:0] code,
  output logic [LEAD_W-1:0] eff,
  output logic              bad
);
  localparam logic [LEAD_W-1:0] LIMIT = LEAD_W'(MAX_CODE);

  assign bad = (code > LIMIT);
  assign eff = bad ? LIMIT : code;
endmodule

// File: rtl/bs_win_timer.sv
`timescale 1ns/1ps
// A countdown slot toward the next window and a slot for the open window.
module bs_win_timer #(
  parameter int HORIZON  = 64,
  parameter int WIN_BITS = 32,
  localparam int CD_W    = $clog2(HORIZON + 1),
  localparam int WC_W    = $clog2(WIN_BITS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            start,
  input  logic            start_sync,
  input  logic            brk,
  output logic            cd_active,
  output logic [CD_W-1:0] cd_left,
  output logic            win_open,
  output logic            win_sync
);
  logic            cd_sync;
  logic            brk_pend;
  logic [WC_W-1:0] wcnt;
  logic            cd_done;

  assign cd_done = tick && cd_active && (cd_left == CD_W'(1));

  // Countdown slot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cd_active <= 1'b0;
      cd_left   <= '0;
      cd_sync   <= 1'b0;
    end else if (start) begin
      cd_active <= 1'b1;
      cd_left   <= CD_W'(HORIZON);
      cd_sync   <= start_sync;
    end else if (tick && brk_pend) begin
      cd_active <= 1'b0;
      cd_left   <= '0;
    end else if (tick && cd_active) begin
      cd_left <= cd_left - 1'b1;
      if (cd_left == CD_W'(1)) cd_active <= 1'b0;
    end
  end

  // Window slot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_open <= 1'b0;
      win_sync <= 1'b0;
      wcnt     <= '0;
    end else if (tick && brk_pend) begin
      win_open <= 1'b0;
    end else if (cd_done && !start) begin
      win_open <= 1'b1;
      win_sync <= cd_sync;
      wcnt     <= '0;
    end else if (tick && win_open) begin
      if (wcnt == WC_W'(WIN_BITS - 1)) win_open <= 1'b0;
      else                             wcnt <= wcnt + 1'b1;
    end
  end

  // Break request waits for the next bit boundary
  always_ff @(posedge clk) begin
    if (!rst_n)    brk_pend <= 1'b0;
    else if (brk)  brk_pend <= 1'b1;
    else if (tick) brk_pend <= 1'b0;
  end

  assert_brk_cancels_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && brk_pend && !start) |=> (!win_open && !cd_active));

  assert_win_follows_cd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_open) |-> $past(cd_active));
endmodule

// File: rtl/pager_bs_seq.sv
`timescale 1ns/1ps
module pager_bs_seq
  import bs_pkg::*;
#(
  parameter int DIV_SLOW = 150,
  parameter int DIV_MID  = 64,
  parameter int DIV_FAST = 32,
  parameter int HORIZON  = 64,
  parameter int WIN_BITS = 32,
  parameter int RF_MAX   = 61,
  parameter int PLL_MAX  = 62
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate_sel,
  input  logic [5:0] rf_lead,
  input  logic [5:0] pll_lead,
  input  logic       dc_opt,
  input  logic [1:0] dec_mode,
  input  logic       win_start,
  input  logic       win_sync,
  input  logic       brk,
  output logic       rf_en,
  output logic       dc_adj,
  output logic       pll_en,
  output logic       cfg_err
);
  localparam int CD_W  = $clog2(HORIZON + 1);
  localparam int CMP_W = (CD_W > LEAD_W) ? CD_W : LEAD_W;

  bs_mode_e          mode;
  logic              tick;
  logic              cd_active, win_open, win_sync_q;
  logic [CD_W-1:0]   cd_left;
  logic [LEAD_W-1:0] raw  [2];
  logic [LEAD_W-1:0] eff  [2];
  logic              bad  [2];
  logic [LEAD_W-1:0] rf_eff, pll_eff;
  logic              rf_lead_on, pll_lead_on;

  assign mode   = bs_mode_e'(dec_mode);
  assign raw[0] = rf_lead;
  assign raw[1] = pll_lead;

  for (genvar gi = 0; gi < 2; gi++) begin : g_clamp
    bs_lead_clamp #(.MAX_CODE(gi == 0 ? RF_MAX : PLL_MAX)) u_clamp (
      .code (raw[gi]),
      .eff  (eff[gi]),
      .bad  (bad[gi])
    );
  end

  assign rf_eff  = eff[0];
  assign pll_eff = eff[1];

  bs_bit_tick #(.DIV_SLOW(DIV_SLOW), .DIV_MID(DIV_MID), .DIV_FAST(DIV_FAST)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_sel (rate_sel),
    .resync   (win_start),
    .tick     (tick)
  );

  bs_win_timer #(.HORIZON(HORIZON), .WIN_BITS(WIN_BITS)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .start      (win_start),
    .start_sync (win_sync),
    .brk        (brk),
    .cd_active  (cd_active),
    .cd_left    (cd_left),
    .win_open   (win_open),
    .win_sync   (win_sync_q)
  );

  assign rf_lead_on  = cd_active && (CMP_W'(cd_left) <= CMP_W'(rf_eff));
  assign pll_lead_on = cd_active && (CMP_W'(cd_left) <= CMP_W'(pll_eff));

  assign rf_en  = win_open || rf_lead_on;
  assign pll_en = win_open || pll_lead_on;

  always_comb begin
    if (dc_opt)
      dc_adj = win_open && ((mode == MODE_IDLE) || (mode == MODE_LOCK && win_sync_q));
    else
      dc_adj = (mode == MODE_IDLE) && rf_lead_on;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_err <= 1'b0;
    else if (win_start && (bad[0] || bad[1] || (pll_eff <= rf_eff))) cfg_err <= 1'b1;
  end

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  assert_pll_covers_rf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pll_eff > rf_eff) && rf_en) |-> pll_en);

  assert_dc_idle_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!dc_opt && dc_adj) |-> (mode == MODE_IDLE && rf_en));

  assert_dc_quiet_pre_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PRE) |-> !dc_adj);
endmodule

// File: tb/sim_pager_bs_seq.sv
`timescale 1ns/1ps
module sim_pager_bs_seq;
  localparam int H = 64;
  localparam int W = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rate_sel = 2'b10;
  logic [5:0] rf_lead = '0, pll_lead = '0;
  logic       dc_opt = 1'b0;
  logic [1:0] dec_mode = 2'b00;
  logic       win_start = 1'b0, win_sync = 1'b0, brk = 1'b0;
  logic       rf_en, dc_adj, pll_en, cfg_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pager_bs_seq #(.HORIZON(H), .WIN_BITS(W)) u0 (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .rf_lead(rf_lead),
    .pll_lead(pll_lead), .dc_opt(dc_opt), .dec_mode(dec_mode),
    .win_start(win_start), .win_sync(win_sync), .brk(brk),
    .rf_en(rf_en), .dc_adj(dc_adj), .pll_en(pll_en), .cfg_err(cfg_err)
  );

  // {rate, rf_lead, pll_lead, dc_opt, dec_mode, win_sync}
  localparam logic [17:0] VEC [0:8] = '{
    {2'd2, 6'd10, 6'd20, 1'b0, 2'd0, 1'b0},
    {2'd2, 6'd0,  6'd5,  1'b0, 2'd0, 1'b0},
    {2'd2, 6'd61, 6'd62, 1'b1, 2'd2, 1'b1},
    {2'd2, 6'd5,  6'd9,  1'b1, 2'd2, 1'b0},
    {2'd2, 6'd5,  6'd9,  1'b1, 2'd0, 1'b0},
    {2'd3, 6'd5,  6'd9,  1'b0, 2'd1, 1'b0},
    {2'd1, 6'd3,  6'd4,  1'b0, 2'd0, 1'b0},
    {2'd0, 6'd2,  6'd3,  1'b1, 2'd2, 1'b1},
    {2'd2, 6'd63, 6'd63, 1'b0, 2'd0, 1'b0}
  };

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic strobe(input logic sync);
    win_sync  = sync;
    win_start = 1'b1;
    adv(1);
    win_start = 1'b0;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int div_of(input int r);
    return (r == 0) ? 150 : (r == 1) ? 64 : 32;
  endfunction

  function automatic int lead_on(input int b, input int lead);
    return ((b < H) && (H - b <= lead)) ? 1 : 0;
  endfunction

  function automatic int open_at(input int b);
    return ((b >= H) && (b < H + W)) ? 1 : 0;
  endfunction

  int err_exp = 0;

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    adv(5);
    check("R1 rf_en in reset", rf_en, 0);
    check("R1 pll_en in reset", pll_en, 0);
    check("R1 dc_adj in reset", dc_adj, 0);
    rst_n = 1'b1;
    adv(3);
    check("R1 outputs after reset", {rf_en, pll_en, dc_adj, cfg_err}, 0);

    // Vector walk: whole strobe-to-window traces
    for (int i = 0; i < 9; i++) begin
      int r, n, m, opt, md, sy, dv, ne, me, tot;
      int rf_a, rf_x, pl_a, pl_x, dc_a, dc_x;
      int r2_v, r10_v;
      string dtag;
      r = VEC[i][17:16]; n = VEC[i][15:10]; m = VEC[i][9:4];
      opt = VEC[i][3]; md = VEC[i][2:1]; sy = VEC[i][0];
      rate_sel = r[1:0]; rf_lead = n[5:0]; pll_lead = m[5:0];
      dc_opt = opt[0]; dec_mode = md[1:0];
      dv = div_of(r);
      ne = (n > 61) ? 61 : n;
      me = (m > 62) ? 62 : m;
      if (n > 61 || m > 62 || me <= ne) err_exp = 1;
      tot = (H + W) * dv;
      rf_a = 0; rf_x = 0; pl_a = 0; pl_x = 0; dc_a = 0; dc_x = 0;
      r2_v = 0; r10_v = 1;
      strobe(sy[0]);
      for (int k = 0; k <= tot; k++) begin
        int b, e_rf, e_pl, e_dc;
        b = k / dv;
        e_rf = open_at(b) | lead_on(b, ne);
        e_pl = open_at(b) | lead_on(b, me);
        if (opt == 0) e_dc = (md == 0) ? lead_on(b, ne) : 0;
        else e_dc = open_at(b) & ((md == 0 || (md == 2 && sy == 1)) ? 1 : 0);
        if (rf_en != e_rf[0] && rf_a == rf_x) begin rf_a = rf_en; rf_x = e_rf; end
        if (pll_en != e_pl[0] && pl_a == pl_x) begin pl_a = pll_en; pl_x = e_pl; end
        if (dc_adj != e_dc[0] && dc_a == dc_x) begin dc_a = dc_adj; dc_x = e_dc; end
        if (k == tot - 1) r2_v = rf_en;
        if (k == tot) r10_v = {rf_en, pll_en, dc_adj};
        adv(1);
      end
      check((i == 8) ? "R5 rf_en clamped trace" : "R3 rf_en trace", rf_a, rf_x);
      check((i == 8) ? "R5 pll_en clamped trace" : "R4 pll_en trace", pl_a, pl_x);
      if (md == 1 || md == 3) dtag = "R9 dc_adj trace";
      else dtag = (opt == 1) ? "R8 dc_adj trace" : "R7 dc_adj trace";
      check(dtag, dc_a, dc_x);
      check("R2 rf_en in last window clock", r2_v, 1);
      check("R10 all low after window", r10_v, 0);
      check("R6 cfg_err", cfg_err, err_exp);
    end

    // R6: sticky flag survives a later legal strobe; clear by reset
    rate_sel = 2'b10; rf_lead = 6'd4; pll_lead = 6'd8;
    strobe(1'b0);
    adv((H + W) * 32 + 2);
    check("R6 cfg_err stays set", cfg_err, 1);
    rst_n = 1'b0; adv(2); rst_n = 1'b1; adv(1);
    check("R1 cfg_err cleared by reset", cfg_err, 0);

    // R10: a newer lead already running bridges the window close
    rf_lead = 6'd55; pll_lead = 6'd60; dc_opt = 1'b0; dec_mode = 2'b00;
    strobe(1'b0);
    adv((H + 20) * 32 - 1);
    strobe(1'b0);
    adv((W - 20) * 32 - 1);
    check("R10 rf_en in last window clock", rf_en, 1);
    adv(1);
    check("R10 rf_en bridged past close", rf_en, 1);
    check("R10 pll_en bridged past close", pll_en, 1);
    check("R7 dc_adj in new lead", dc_adj, 1);
    adv((52 + W) * 32 + 2);
    check("R10 low after second window", {rf_en, pll_en, dc_adj}, 0);
    check("R6 legal leads keep cfg_err low", cfg_err, 0);

    // R11: break in the middle of a window
    rf_lead = 6'd4; pll_lead = 6'd8; dc_opt = 1'b1; dec_mode = 2'b10;
    strobe(1'b1);
    adv((H + 5) * 32 + 3);
    check("R8 dc_adj in sync window", dc_adj, 1);
    check("R3 rf_en inside window", rf_en, 1);
    brk = 1'b1; adv(1); brk = 1'b0;
    adv(32);
    check("R11 all low within a bit", {rf_en, pll_en, dc_adj}, 0);
    adv(40 * 32);
    check("R11 window stays closed", {rf_en, pll_en, dc_adj}, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule